// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block provides several timed events from one time base. A 16-bit counter runs freely and is advanced only by a prescaled tick. No software write can load it. Up to seven compare channels (default four) watch this counter. Each channel raises its own sticky flag when the counter steps onto that channel's compare value. Software can create periodic events at different rates in two ways. It can move each compare value forward itself, or it can set a channel to auto-advance, so that on every match the hardware adds a per-channel interval to the compare value.

Channel 0 drives an interrupt line of its own. Channels 1 and up share a second line. A source code names the lowest-numbered enabled channel that is pending, and reading that code acknowledges the channel. A compare write may land on a value the counter has just reached or recently passed. In that case the flag is set at the write, so the event is not lost for a whole counter wrap. A value counts as recently passed when it lies less than a fixed window (default 256 counts) behind the count that results from that edge.

Register map (`addr`):

| Address | Register | Access |
|---|---|---|
| 0 | Counter | Read only; writes are ignored |
| 1 | Interrupt enable mask | Read/write |
| 2 | Auto-advance mask | Read/write |
| 3 | Flags | Read; writing 1 to a bit clears that flag |
| 4 | Source code | Read returns the code; a read with `rd_en` clears that channel's flag |
| 8+i | Compare value of channel i | Read/write |
| 16+i | Interval of channel i | Read/write |

Top module: `cmp_timer`

## Requirements
- R1: The counter starts at 0 after reset. It advances by one every `presc_div`+1 clocks and wraps from 0xFFFF to 0x0000. A write to address 0 has no effect on it.
- R2: When the counter steps onto channel i's compare value, flag bit i (bit i of address 3) is set on that same clock edge.
- R3: A flag stays set until a write to address 3 has a 1 in that flag's bit position. If a clear and a set hit the same bit on the same edge, the flag ends set.
- R4: `irq_ch0` is high exactly when flag 0 is set and enable bit 0 (address 1) is set.
- R5: `irq_shared` is high exactly when at least one channel numbered 1 or higher has both its flag and its enable bit set.
- R6: `src_code` (also readable at address 4) is the lowest channel number at or above 1 whose flag and enable are both set, or 0 if there is none. Reading address 4 with `rd_en` clears the flag of the channel it returns.
- R7: A write of value v to address 8+i sets flag i on that edge when (count after the edge − v) mod 65536 is less than 256. Otherwise the flag is not set by the write.
- R8: When auto-advance bit i (address 2) is set, each match on channel i adds the channel's interval (address 16+i) to its compare value. The next match then happens that many ticks later.
- R9: A disabled channel still sets its flag on a match, but it raises no interrupt and does not appear in `src_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| presc_div | input | 8 | Tick every `presc_div`+1 clocks |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; acts only on the source register |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq_ch0 | output | 1 | Channel 0 interrupt |
| irq_shared | output | 1 | Shared interrupt for channels 1 and up |
| src_code | output | 3 | Lowest pending enabled channel at or above 1, or 0 |

## Verification
A table of channel and offset pairs sets compare values a few ticks to several hundred ticks ahead of the counter on each channel. Each pair checks that the flag is still clear one tick before the target and set on the exact tick, and that the right interrupt line and source code follow. Late writes are tried at a distance of zero, at the last value inside the window and at the first value outside it. These separate an immediate flag from an armed future match. Directed cases cover a clear that collides with a match, priority and read-acknowledge order across two pending channels, a disabled channel, the auto-advance period, prescaled tick spacing, an ignored write to the counter, and the wrap through 0xFFFF.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int NCH      = 4,
  parameter int CW       = 16,
  parameter int PW       = 8,
  parameter int AW       = 5,
  parameter int LATE_WIN = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc_div,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq_ch0,
  output logic          irq_shared,
  output logic [2:0]    src_code
);
  localparam int A_CNT  = 0;
  localparam int A_EN   = 1;
  localparam int A_AUTO = 2;
  localparam int A_FLAG = 3;
  localparam int A_SRC  = 4;
  localparam int A_CMP  = 8;
  localparam int A_IVL  = 16;

  logic [PW-1:0]  pcnt;
  logic           tick;
  logic [CW-1:0]  cnt, cnt_nx;
  logic [CW-1:0]  cmp [NCH];
  logic [CW-1:0]  ivl [NCH];
  logic [NCH-1:0] en, auto_m, flag, hit, late, clr, pend;

  assign tick   = pcnt >= presc_div;
  assign cnt_nx = tick ? cnt + CW'(1) : cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0;
      cnt  <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + PW'(1);
      cnt  <= cnt_nx;
    end

  always_comb
    for (int i = 0; i < NCH; i++) begin
      hit[i]  = tick && (cnt_nx == cmp[i]);
      late[i] = wr_en && (addr == AW'(A_CMP + i)) &&
                (CW'(cnt_nx - wdata) < CW'(LATE_WIN));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cmp[i] <= '0;
        ivl[i] <= '0;
      end
      en     <= '0;
      auto_m <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && addr == AW'(A_CMP + i))
          cmp[i] <= wdata;
        else if (hit[i] && auto_m[i])
          cmp[i] <= cmp[i] + ivl[i];
        if (wr_en && addr == AW'(A_IVL + i))
          ivl[i] <= wdata;
      end
      if (wr_en && addr == AW'(A_EN))   en     <= wdata[NCH-1:0];
      if (wr_en && addr == AW'(A_AUTO)) auto_m <= wdata[NCH-1:0];
    end

  assign pend = flag & en;

  always_comb begin
    src_code = '0;
    for (int i = NCH - 1; i >= 1; i--)
      if (pend[i]) src_code = 3'(i);
  end

  always_comb begin
    clr = '0;
    if (wr_en && addr == AW'(A_FLAG)) clr = wdata[NCH-1:0];
    if (rd_en && addr == AW'(A_SRC) && src_code != '0)
      clr = clr | (NCH'(1) << src_code);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | hit | late;

  assign irq_ch0    = pend[0];
  assign irq_shared = |pend[NCH-1:1];

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CNT):  rdata = cnt;
      AW'(A_EN):   rdata = CW'(en);
      AW'(A_AUTO): rdata = CW'(auto_m);
      AW'(A_FLAG): rdata = CW'(flag);
      AW'(A_SRC):  rdata = CW'(src_code);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(A_CMP + i)) rdata = cmp[i];
      if (addr == AW'(A_IVL + i)) rdata = ivl[i];
    end
  end

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CW'($past(cnt) + CW'(1)));
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_src_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> src_code != '0);
  assert_src_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_code != '0 |-> flag[src_code] && en[src_code]);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_hit_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag[g]);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag[g] && !clr[g] |=> flag[g]);
    assert_late_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      late[g] |=> flag[g]);
  end
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  presc_div;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wdata, rdata;
  logic        irq_ch0, irq_shared;
  logic [2:0]  src_code;

  always #5 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_ch0(irq_ch0), .irq_shared(irq_shared), .src_code(src_code));

  int checks = 0;
  int errors = 0;

  localparam int NV = 6;
  localparam int V_CH  [NV] = '{0, 1, 2, 3, 1, 3};
  localparam int V_OFF [NV] = '{5, 3, 10, 2, 300, 40};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = 5'(a); wdata = 16'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    addr = 5'(a); #1; v = rdata;
  endtask

  task automatic rdc(int a, output logic [15:0] v);
    addr = 5'(a); rd_en = 1'b1; #1; v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c, v, f;
    int n;
    rst_n = 1'b0; presc_div = '0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rd(0, v); check("R1 reset count", v, 0);
    rd(3, v); check("R3 reset flags", v, 0);
    check("R4 reset irq_ch0", irq_ch0, 0);
    check("R6 reset src_code", src_code, 0);
    rst_n = 1'b1;
    wr(1, 'hF);

    // R2 table: compare set a given offset ahead on one channel
    for (int k = 0; k < NV; k++) begin
      wr(3, 'hF);
      rd(0, c);
      wr(8 + V_CH[k], c + V_OFF[k]);
      repeat (V_OFF[k] - 2) @(negedge clk);
      rd(3, f); check("R2 flag before match", f[V_CH[k]], 0);
      @(negedge clk);
      rd(0, v); check("R2 count at match", v, 16'(c + V_OFF[k]));
      rd(3, f); check("R2 flag at match", f[V_CH[k]], 1);
      if (V_CH[k] == 0) check("R4 irq_ch0 on match", irq_ch0, 1);
      else begin
        check("R5 irq_shared on match", irq_shared, 1);
        check("R6 src_code on match", src_code, V_CH[k]);
      end
    end

    // R7 late-write window boundaries on channel 1
    wr(3, 'hF); rd(0, c); wr(9, c + 1);
    rd(3, f); check("R7 late distance 0", f[1], 1);
    wr(3, 'hF); rd(0, c); wr(9, 16'(c + 1 - 255));
    rd(3, f); check("R7 late distance 255", f[1], 1);
    wr(3, 'hF); rd(0, c); wr(9, 16'(c + 1 - 256));
    rd(3, f); check("R7 distance 256 not late", f[1], 0);

    // R3 clear colliding with a match: set wins, then sticky, then clears
    wr(3, 'hF); rd(0, c); wr(9, c + 3);
    @(negedge clk);
    wr(3, 'h2);
    rd(3, f); check("R3 set beats clear", f[1], 1);
    repeat (20) @(negedge clk);
    rd(3, f); check("R3 sticky flag", f[1], 1);
    wr(3, 'h2);
    rd(3, f); check("R3 write-one clears", f[1], 0);

    // R6 priority and read-acknowledge
    wr(3, 'hF);
    rd(0, c); wr(10, c + 1);
    rd(0, c); wr(9, c + 1);
    check("R6 lowest channel first", src_code, 1);
    rdc(4, v); check("R6 read returns code", v, 1);
    check("R6 next pending channel", src_code, 2);
    rd(3, f); check("R6 read clears channel 1", f[1], 0);
    rdc(4, v); check("R6 second read", v, 2);
    check("R5 irq_shared drops", irq_shared, 0);

    // R9 disabled channels, R4 enable gating
    wr(1, 'hD); wr(3, 'hF);
    rd(0, c); wr(9, c + 1);
    rd(3, f); check("R9 disabled flag still sets", f[1], 1);
    check("R9 disabled no irq_shared", irq_shared, 0);
    check("R9 disabled not in src_code", src_code, 0);
    wr(1, 0); rd(0, c); wr(8, c + 1);
    check("R4 irq_ch0 gated off", irq_ch0, 0);
    wr(1, 1);
    check("R4 irq_ch0 on enable", irq_ch0, 1);

    // R8 auto-advance on channel 2 with interval 7
    wr(1, 'hF); wr(2, 'h4); wr(18, 7); wr(3, 'hF);
    rd(0, c); wr(10, c + 3);
    @(negedge clk); @(negedge clk);
    rd(3, f); check("R8 first match", f[2], 1);
    rd(10, v); check("R8 compare advanced", v, 16'(c + 10));
    wr(3, 'h4);
    repeat (5) @(negedge clk);
    rd(3, f); check("R8 before second match", f[2], 0);
    @(negedge clk);
    rd(3, f); check("R8 second match", f[2], 1);
    wr(2, 0);

    // R1 prescaler spacing and ignored counter write
    presc_div = 8'd3;
    rd(0, c);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk); rd(0, v);
      if (v != c) break;
    end
    c = v; n = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk); n++; rd(0, v);
      if (v != c) break;
    end
    check("R1 prescaled tick spacing", n, 4);
    rd(0, c); wr(0, 'h1234); rd(0, v);
    check("R1 counter write ignored", int'(v == c || v == 16'(c + 1)), 1);

    // R1 wrap
    presc_div = '0; wr(1, 0);
    for (int j = 0; j < 70000; j++) begin
      rd(0, v);
      if (v == 16'hFFFF) break;
      @(negedge clk);
    end
    check("R1 reaches all ones", v, 16'hFFFF);
    @(negedge clk);
    rd(0, v); check("R1 wraps to zero", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule